// File: doc/BRIEF.md
# Runahead Mode Controller

This block decides when a small out-of-order window stops retiring for real and starts pre-executing speculatively. It watches the oldest window entry. When that entry is a load that missed in the cache and has not completed, it takes a snapshot of the register file and switches into runahead operation. While running ahead it removes entries from the head in order without touching architectural state. It tracks, per register, whether a value depends on the outstanding miss. It also gates branch recovery and prefetch issue on that tracking.

When the miss data comes back, the block flushes the window, copies the snapshot back, clears every dependency bit and steers fetch to the load that started the episode. A read port exposes the working register values and their dependency bits.

The controller is a four-state machine:
- `ST_NORMAL`: ordinary retirement.
- `ST_CKPT`: one cycle in which the snapshot is taken.
- `ST_RUN`: pseudo-retirement.
- `ST_RESTORE`: one cycle of flush, restore and redirect.

Its transitions are:
- T_MISS_DETECT: `ST_NORMAL` to `ST_CKPT`.
- T_CKPT_DONE: `ST_CKPT` to `ST_RUN`.
- T_MISS_RETURN: `ST_RUN` to `ST_RESTORE`.
- T_RESUME: `ST_RESTORE` to `ST_NORMAL`.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset `mode` is 0, every strobe output is 0, and every register reads 0 with its dependency bit (`rd_inv`) 0.
- R2: In normal mode, a valid and complete head entry is deallocated and `arch_commit` pulses in that cycle. When `head_has_dst` is set, `head_result` is written to `head_dst` with its dependency bit cleared. A store head (`head_is_st`) also pulses `store_commit`. A head that is not complete waits.
- R3: In normal mode, a valid head with `head_miss`=1 and `head_done`=0 is not deallocated. In the next cycle `ckpt_take` is 1 for exactly that cycle and `mode` becomes 1. In that same cycle the triggering load is deallocated and its destination dependency bit is set.
- R4: While `mode` is 1, `arch_commit` and `store_commit` stay 0.
- R5: In runahead mode the dependency bit of a head entry is the OR of the dependency bits of `head_src_a` and `head_src_b`. An entry whose bit is set is deallocated at once even if not complete. It marks its destination dependent and leaves the destination value unchanged.
- R6: In runahead mode, a head entry with no dependent source is deallocated only once `head_done` is 1. It then writes its result with the dependency bit cleared.
- R7: `br_recover` pulses when a complete branch with `head_br_mispred`=1 is deallocated and none of its sources is dependent. A runahead branch with a dependent source is deallocated without recovery.
- R8: `pf_en` is 1 only in `ST_RUN`, for a valid head with `head_miss`=1 whose two sources are both non-dependent.
- R9: A further miss at the head while in runahead mode takes no new snapshot. It is deallocated at once with its destination marked dependent.
- R10: A `miss_ret` pulse in `ST_RUN` blocks deallocation in that cycle. In the next cycle `flush`, `ckpt_restore` and `redirect_vld` are 1 and `redirect_pc` holds the triggering load's `head_pc`. After that, `mode` is 0, every register holds its snapshot value, and every dependency bit is 0.
- R11: A `miss_ret` pulse in normal mode has no effect. A pulse during the snapshot cycle is remembered, and exit follows after one runahead cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_vld | input | 1 | Oldest window entry present |
| head_miss | input | 1 | Oldest entry is a long-latency miss load |
| head_done | input | 1 | Oldest entry has completed |
| head_pc | input | PC_W | Address of the oldest entry |
| head_has_dst | input | 1 | Oldest entry writes a register |
| head_dst | input | RIDX_W | Destination register index |
| head_src_a | input | RIDX_W | First source register index |
| head_src_b | input | RIDX_W | Second source register index |
| head_result | input | DATA_W | Result value of the oldest entry |
| head_is_br | input | 1 | Oldest entry is a branch |
| head_br_mispred | input | 1 | Branch outcome disagrees with prediction |
| head_is_st | input | 1 | Oldest entry is a store |
| miss_ret | input | 1 | Data for the triggering miss has returned |
| rd_idx | input | RIDX_W | Register read index |
| mode | output | 1 | Runahead operation active |
| ckpt_take | output | 1 | Snapshot strobe |
| ckpt_restore | output | 1 | Snapshot restore strobe |
| dealloc | output | 1 | Remove oldest entry this cycle |
| flush | output | 1 | Empty the window |
| redirect_vld | output | 1 | Fetch redirect valid |
| redirect_pc | output | PC_W | Fetch redirect target |
| arch_commit | output | 1 | Architectural retirement strobe |
| store_commit | output | 1 | Memory write permitted |
| br_recover | output | 1 | Mispredicted branch recovery |
| pf_en | output | 1 | Prefetch from the head address allowed |
| rd_data | output | DATA_W | Register value at `rd_idx` |
| rd_inv | output | 1 | Dependency bit at `rd_idx` |

## Verification
The assertions watch several rules on every cycle:
- no commit strobe while running ahead;
- a snapshot only ever out of normal mode, as a single pulse;
- restore always paired with flush, without deallocation, and followed by normal mode with clean dependency bits;
- prefetch and recovery never acting on a dependent source.

Other behaviours can only be shown by the bench's scenarios. These are the cycle at which each entry leaves the window, the OR-propagation of dependency bits through a chain of registers, the restored register values and the redirect target. The late-return and ignored-return corners also need scenarios.

// File: rtl/ra_pkg.sv
package ra_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_CKPT    = 2'd1,
        ST_RUN     = 2'd2,
        ST_RESTORE = 2'd3
    } ra_state_e;
endpackage

// File: rtl/ra_fsm.sv
module ra_fsm
    import ra_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            head_vld,
    input  logic            head_miss,
    input  logic            head_done,
    input  logic [PC_W-1:0] head_pc,
    input  logic            miss_ret,
    output ra_state_e       state,
    output logic [PC_W-1:0] trig_pc,
    output logic            mode,
    output logic            ckpt_take,
    output logic            restore,
    output logic            ret_now
);
    ra_state_e state_q, state_d;
    logic      ret_pend_q;
    logic      start_miss;

    assign start_miss = head_vld && head_miss && !head_done;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    // trigger address and early-return memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_pc    <= '0;
            ret_pend_q <= 1'b0;
        end else begin
            if (state_q == ST_NORMAL && start_miss) begin
                trig_pc <= head_pc;
            end
            if (state_q == ST_CKPT) begin
                ret_pend_q <= miss_ret;
            end else if (state_q == ST_RESTORE) begin
                ret_pend_q <= 1'b0;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL:  if (start_miss) state_d = ST_CKPT;               // T_MISS_DETECT
            ST_CKPT:    state_d = ST_RUN;                                // T_CKPT_DONE
            ST_RUN:     if (miss_ret || ret_pend_q) state_d = ST_RESTORE; // T_MISS_RETURN
            ST_RESTORE: state_d = ST_NORMAL;                             // T_RESUME
            default:    state_d = ST_NORMAL;
        endcase
    end

    // outputs
    always_comb begin
        mode      = 1'b0;
        ckpt_take = 1'b0;
        restore   = 1'b0;
        ret_now   = 1'b0;
        unique case (state_q)
            ST_NORMAL: ;
            ST_CKPT: begin
                mode      = 1'b1;
                ckpt_take = 1'b1;
            end
            ST_RUN: begin
                mode    = 1'b1;
                ret_now = miss_ret || ret_pend_q;
            end
            ST_RESTORE: begin
                mode    = 1'b1;
                restore = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/ra_regfile.sv
module ra_regfile #(
    parameter int NREG   = 8,
    parameter int DATA_W = 8,
    localparam int RIDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_inv,
    input  logic              ckpt_take,
    input  logic              restore,
    input  logic [RIDX_W-1:0] src_a,
    input  logic [RIDX_W-1:0] src_b,
    output logic              src_inv,
    input  logic [RIDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_inv
);
    logic [DATA_W-1:0] val_arr [NREG];
    logic              inv_arr [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DATA_W-1:0] work_q;
        logic [DATA_W-1:0] snap_q;
        logic              inv_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                work_q <= '0;
                snap_q <= '0;
                inv_q  <= 1'b0;
            end else begin
                if (restore) begin
                    work_q <= snap_q;
                    inv_q  <= 1'b0;
                end else if (wr_en && (wr_idx == RIDX_W'(g))) begin
                    inv_q <= wr_inv;
                    if (!wr_inv) begin
                        work_q <= wr_data;
                    end
                end
                if (ckpt_take) begin
                    snap_q <= work_q;
                end
            end
        end

        assign val_arr[g] = work_q;
        assign inv_arr[g] = inv_q;
    end

    assign src_inv = inv_arr[src_a] || inv_arr[src_b];
    assign rd_data = val_arr[rd_idx];
    assign rd_inv  = inv_arr[rd_idx];
endmodule

// File: rtl/ra_retire.sv
module ra_retire
    import ra_pkg::*;
(
    input  ra_state_e state,
    input  logic      head_vld,
    input  logic      head_miss,
    input  logic      head_done,
    input  logic      head_is_br,
    input  logic      head_br_mispred,
    input  logic      head_is_st,
    input  logic      head_has_dst,
    input  logic      src_inv,
    input  logic      ret_now,
    output logic      dealloc,
    output logic      wr_en,
    output logic      wr_inv,
    output logic      arch_commit,
    output logic      store_commit,
    output logic      br_recover,
    output logic      pf_en
);
    logic entry_inv;
    logic leave;

    assign entry_inv = src_inv || (head_miss && !head_done);

    always_comb begin
        leave        = 1'b0;
        wr_inv       = 1'b0;
        arch_commit  = 1'b0;
        store_commit = 1'b0;
        br_recover   = 1'b0;
        pf_en        = 1'b0;
        unique case (state)
            ST_NORMAL: begin
                leave        = head_vld && head_done;
                arch_commit  = leave;
                store_commit = leave && head_is_st;
                br_recover   = leave && head_is_br && head_br_mispred;
            end
            ST_CKPT: begin
                leave  = head_vld;
                wr_inv = 1'b1;
            end
            ST_RUN: begin
                leave      = head_vld && !ret_now && (entry_inv || head_done);
                wr_inv     = entry_inv;
                br_recover = leave && !entry_inv && head_is_br && head_br_mispred;
                pf_en      = head_vld && head_miss && !src_inv;
            end
            ST_RESTORE: ;
            default: ;
        endcase
    end

    assign dealloc = leave;
    assign wr_en   = leave && head_has_dst;
endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl
    import ra_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int DATA_W = 8,
    parameter int PC_W   = 16,
    localparam int RIDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_vld,
    input  logic              head_miss,
    input  logic              head_done,
    input  logic [PC_W-1:0]   head_pc,
    input  logic              head_has_dst,
    input  logic [RIDX_W-1:0] head_dst,
    input  logic [RIDX_W-1:0] head_src_a,
    input  logic [RIDX_W-1:0] head_src_b,
    input  logic [DATA_W-1:0] head_result,
    input  logic              head_is_br,
    input  logic              head_br_mispred,
    input  logic              head_is_st,
    input  logic              miss_ret,
    input  logic [RIDX_W-1:0] rd_idx,
    output logic              mode,
    output logic              ckpt_take,
    output logic              ckpt_restore,
    output logic              dealloc,
    output logic              flush,
    output logic              redirect_vld,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              arch_commit,
    output logic              store_commit,
    output logic              br_recover,
    output logic              pf_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_inv
);
    ra_state_e       state;
    logic [PC_W-1:0] trig_pc;
    logic            restore;
    logic            ret_now;
    logic            src_inv;
    logic            wr_en;
    logic            wr_inv;

    ra_fsm #(.PC_W(PC_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_vld  (head_vld),
        .head_miss (head_miss),
        .head_done (head_done),
        .head_pc   (head_pc),
        .miss_ret  (miss_ret),
        .state     (state),
        .trig_pc   (trig_pc),
        .mode      (mode),
        .ckpt_take (ckpt_take),
        .restore   (restore),
        .ret_now   (ret_now)
    );

    ra_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (head_dst),
        .wr_data   (head_result),
        .wr_inv    (wr_inv),
        .ckpt_take (ckpt_take),
        .restore   (restore),
        .src_a     (head_src_a),
        .src_b     (head_src_b),
        .src_inv   (src_inv),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .rd_inv    (rd_inv)
    );

    ra_retire u_ret (
        .state           (state),
        .head_vld        (head_vld),
        .head_miss       (head_miss),
        .head_done       (head_done),
        .head_is_br      (head_is_br),
        .head_br_mispred (head_br_mispred),
        .head_is_st      (head_is_st),
        .head_has_dst    (head_has_dst),
        .src_inv         (src_inv),
        .ret_now         (ret_now),
        .dealloc         (dealloc),
        .wr_en           (wr_en),
        .wr_inv          (wr_inv),
        .arch_commit     (arch_commit),
        .store_commit    (store_commit),
        .br_recover      (br_recover),
        .pf_en           (pf_en)
    );

    assign ckpt_restore = restore;
    assign flush        = restore;
    assign redirect_vld = restore;
    assign redirect_pc  = restore ? trig_pc : '0;
endmodule

// File: rtl/ra_checker.sv
module ra_checker (
    input logic clk,
    input logic rst_n,
    input logic mode,
    input logic ckpt_take,
    input logic ckpt_restore,
    input logic flush,
    input logic dealloc,
    input logic arch_commit,
    input logic store_commit,
    input logic br_recover,
    input logic pf_en,
    input logic src_inv,
    input logic rd_inv
);
    AST_SNAPSHOT_FROM_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_take |-> !$past(mode)); // R9

    AST_SNAPSHOT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_take |=> (!ckpt_take && mode)); // R3

    AST_NO_ARCH_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> (!arch_commit && !store_commit)); // R4

    AST_RESTORE_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_restore |-> (flush && !dealloc)); // R10

    AST_RESTORE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_restore |=> (!mode && !rd_inv)); // R10

    AST_RECOVER_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (br_recover && mode) |-> !src_inv); // R7

    AST_PREFETCH_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pf_en |-> (mode && !src_inv)); // R8
endmodule

bind runahead_ctrl ra_checker i_ra_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .ckpt_take    (ckpt_take),
    .ckpt_restore (ckpt_restore),
    .flush        (flush),
    .dealloc      (dealloc),
    .arch_commit  (arch_commit),
    .store_commit (store_commit),
    .br_recover   (br_recover),
    .pf_en        (pf_en),
    .src_inv      (src_inv),
    .rd_inv       (rd_inv)
);

// File: tb/test_runahead_ctrl.sv
module test_runahead_ctrl;
    localparam int NREG   = 8;
    localparam int DATA_W = 8;
    localparam int PC_W   = 16;
    localparam int RW     = $clog2(NREG);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic head_vld = 0, head_miss = 0, head_done = 0, head_has_dst = 0;
    logic head_is_br = 0, head_br_mispred = 0, head_is_st = 0, miss_ret = 0;
    logic [PC_W-1:0]   head_pc = '0;
    logic [RW-1:0]     head_dst = '0, head_src_a = '0, head_src_b = '0, rd_idx = '0;
    logic [DATA_W-1:0] head_result = '0;
    logic mode, ckpt_take, ckpt_restore, dealloc, flush, redirect_vld;
    logic arch_commit, store_commit, br_recover, pf_en, rd_inv;
    logic [PC_W-1:0]   redirect_pc;
    logic [DATA_W-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    runahead_ctrl #(.NREG(NREG), .DATA_W(DATA_W), .PC_W(PC_W)) i_runahead_ctrl (.*);

    typedef struct packed {
        logic vld, miss, done, br, mp, st, hd;
        logic [2:0]  dst, sa, sb;
        logic [7:0]  res;
        logic [15:0] pc;
        logic        ret;
        logic [2:0]  ri;
        logic [7:0]  eflags; // mode dealloc commit stcommit ckpt flush recover pf
        logic        e_inv;
        logic [7:0]  e_dat;
    } row_t;

    localparam int NROW = 16;
    localparam row_t TBL [NROW] = '{
        // R2 plain retire writes r1
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 3'd1,3'd0,3'd0, 8'h11, 16'h0000, 1'b0, 3'd1, 8'b0110_0000, 1'b0, 8'h00},
        // R2 store retire
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 3'd0,3'd0,3'd0, 8'h00, 16'h0000, 1'b0, 3'd1, 8'b0111_0000, 1'b0, 8'h11},
        // R7 mispredicted branch in normal mode
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 3'd0,3'd1,3'd0, 8'h00, 16'h0000, 1'b0, 3'd1, 8'b0110_0010, 1'b0, 8'h11},
        // R3 miss at head stalls
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd2,3'd1,3'd0, 8'h00, 16'h0040, 1'b0, 3'd2, 8'b0000_0000, 1'b0, 8'h00},
        // R3 snapshot cycle, load leaves
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd2,3'd1,3'd0, 8'h00, 16'h0040, 1'b0, 3'd2, 8'b1100_1000, 1'b0, 8'h00},
        // R5 dependent add leaves at once, r2 now dependent
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd3,3'd2,3'd1, 8'h00, 16'h0000, 1'b0, 3'd2, 8'b1100_0000, 1'b1, 8'h00},
        // R6 valid entry waits
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd4,3'd1,3'd0, 8'h44, 16'h0000, 1'b0, 3'd3, 8'b1000_0000, 1'b1, 8'h00},
        // R6 valid entry completes
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 3'd4,3'd1,3'd0, 8'h44, 16'h0000, 1'b0, 3'd4, 8'b1100_0000, 1'b0, 8'h00},
        // R7 dependent branch: no recovery
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 3'd0,3'd3,3'd0, 8'h00, 16'h0000, 1'b0, 3'd4, 8'b1100_0000, 1'b0, 8'h44},
        // R7 valid branch recovers
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 3'd0,3'd4,3'd0, 8'h00, 16'h0000, 1'b0, 3'd3, 8'b1100_0010, 1'b1, 8'h00},
        // R9 R8 second miss, valid address: prefetch, no snapshot
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd5,3'd1,3'd0, 8'h00, 16'h0000, 1'b0, 3'd5, 8'b1100_0001, 1'b0, 8'h00},
        // R8 miss with dependent address: no prefetch
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd6,3'd3,3'd0, 8'h00, 16'h0000, 1'b0, 3'd5, 8'b1100_0000, 1'b1, 8'h00},
        // R4 store pseudo-retires without memory write
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 3'd0,3'd4,3'd0, 8'h00, 16'h0000, 1'b0, 3'd6, 8'b1100_0000, 1'b1, 8'h00},
        // R10 return blocks dealloc
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 3'd7,3'd0,3'd0, 8'h77, 16'h0000, 1'b1, 3'd4, 8'b1000_0000, 1'b0, 8'h44},
        // R10 restore cycle
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,3'd0,3'd0, 8'h00, 16'h0000, 1'b0, 3'd4, 8'b1000_0100, 1'b0, 8'h44},
        // R10 back to normal, r4 restored
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,3'd0,3'd0, 8'h00, 16'h0000, 1'b0, 3'd4, 8'b0000_0000, 1'b0, 8'h00}
    };

    function automatic logic [7:0] flags();
        return {mode, dealloc, arch_commit, store_commit, ckpt_take, flush, br_recover, pf_en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        head_vld = 0; head_miss = 0; head_done = 0; head_is_br = 0;
        head_br_mispred = 0; head_is_st = 0; head_has_dst = 0; miss_ret = 0;
        head_pc = '0; head_dst = '0; head_src_a = '0; head_src_b = '0; head_result = '0;
    endtask

    task automatic drive(input row_t r);
        head_vld = r.vld; head_miss = r.miss; head_done = r.done; head_is_br = r.br;
        head_br_mispred = r.mp; head_is_st = r.st; head_has_dst = r.hd;
        head_dst = r.dst; head_src_a = r.sa; head_src_b = r.sb; head_result = r.res;
        head_pc = r.pc; miss_ret = r.ret; rd_idx = r.ri;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk("R1 flags", 32'(flags()), 32'h0);
        chk("R1 redirect", 32'({redirect_vld, ckpt_restore}), 32'h0);
        for (int i = 0; i < NREG; i++) begin
            rd_idx = RW'(i);
            #1;
            chk("R1 regs", 32'({rd_inv, rd_data}), 32'h0);
        end

        // table walk
        for (int k = 0; k < NROW; k++) begin
            @(negedge clk);
            drive(TBL[k]);
            #2;
            chk($sformatf("row%0d flags", k), 32'(flags()), 32'(TBL[k].eflags));
            chk($sformatf("row%0d read", k), 32'({rd_inv, rd_data}), 32'({TBL[k].e_inv, TBL[k].e_dat}));
            if (TBL[k].eflags[2]) begin
                chk("R10 redirect", 32'({redirect_vld, ckpt_restore, redirect_pc}), 32'({2'b11, 16'h0040}));
            end
        end

        // R10 all dependency bits cleared, r1 kept from snapshot
        @(negedge clk);
        idle();
        for (int i = 0; i < NREG; i++) begin
            rd_idx = RW'(i);
            #1;
            chk("R10 inv cleared", 32'(rd_inv), 32'h0);
        end
        rd_idx = 3'd1;
        #1;
        chk("R10 r1 snapshot", 32'(rd_data), 32'h11);

        // R11 return in normal mode is ignored
        @(negedge clk);
        miss_ret = 1;
        #2;
        chk("R11 ignored now", 32'(flags()), 32'h0);
        @(negedge clk);
        miss_ret = 0;
        #2;
        chk("R11 ignored next", 32'({flags(), ckpt_restore}), 32'h0);
        chk("R11 r1 kept", 32'(rd_data), 32'h11);

        // R11 return during snapshot cycle
        @(negedge clk);
        head_vld = 1; head_miss = 1; head_has_dst = 1; head_dst = 3'd1; head_pc = 16'h0080;
        #2;
        chk("R3 stall", 32'(dealloc), 32'h0);
        @(negedge clk);
        miss_ret = 1;
        #2;
        chk("R3 snapshot", 32'({ckpt_take, dealloc, mode}), 32'h7);
        @(negedge clk);
        idle();
        #2;
        chk("R11 one run cycle", 32'(flags()), 32'h80);
        @(negedge clk);
        #2;
        chk("R11 restore", 32'({flush, redirect_vld, redirect_pc}), 32'({2'b11, 16'h0080}));
        @(negedge clk);
        rd_idx = 3'd1;
        #2;
        chk("R11 resumed", 32'({mode, rd_inv, rd_data}), 32'h11);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule